// File: doc/BRIEF.md
# Data Cache Access Decision Controller

This block sits next to the tag array of a set-associative data cache and decides, for one access per cycle, what happens to it. It takes the access attributes (read or write, atomic, global or local), the outcome of the tag probe, the state of the miss-status holding registers (MSHRs), the dirty state and address of the way that a fill would replace, and the current occupancy of the bounded miss queue. It returns, in the same cycle, a result code, the line-state updates for the tag array and up to three ordered miss-queue entries.

Three configuration pins stay static during operation. The first selects the write policy: read-only, write-back or write-through. The second selects scope, private or shared. The third selects write-allocate or no-write-allocate. Before it issues any request, the controller reserves the worst-case number of queue slots the access could need. An access that cannot be fully served is rejected with no side effects, and the requester retries it later.

Top module: `dcache_access_ctl`

## Requirements
- R1: An access that needs n extra queue slots is rejected (result 2) when mq_count + n >= MQ_CAP. n is 0 for a write-through write hit, a no-allocate write miss and any read miss in read-only mode. n is 1 for a read miss in the other modes and 2 for a write-allocate write miss.
- R2: A write hit goes through to memory when cfg_wpol is 2 (write-through), or when cfg_shared is 0 and the access is global. If admitted, slot 0 holds a kind-0 (write) entry at acc_addr, ev_write_sent and line_invalidate rise, lru_touch stays low and the result is 0 (hit).
- R3: Any other hit raises lru_touch with result 0 and no queue entry. line_set_modified rises for a write, and for an atomic read.
- R4: A write miss without write-allocate places one kind-0 entry at acc_addr and raises ev_write_sent. The result is 1 (miss), and there is no MSHR add and no LRU touch.
- R5: A write-allocate write miss is rejected with no side effects when R1 fails with n=2. It is also rejected when the MSHR cannot take the line: mshr_full is high, or mshr_hit is low and the queue has no room.
- R6: An admitted write-allocate write miss enqueues a kind-0 write first. If mshr_hit is low, a kind-2 (allocate read) entry at the line address follows. If victim_dirty is high, a kind-3 (writeback) entry at victim_addr comes next. mshr_add and lru_touch rise, and ev_wb_sent stays low.
- R7: On a read miss, mshr_hit merges the access into the MSHR with no read entry. Otherwise a kind-1 (read) entry goes to the line address, and ev_read_sent rises with it. Outside read-only mode, a dirty victim adds a kind-3 entry and ev_wb_sent. If the MSHR is full, the access is rejected.
- R8: A probe status of 2 or 3 (reservation fail) gives result 2 with no queue entry and no line or MSHR update.
- R9: In read-only mode (cfg_wpol 0), a write raises illegal_access with result 2, and a read miss never enqueues a writeback.
- R10: Entries are packed into slots from slot 0 upward with no gaps. Their order is always write, read, writeback. The line address is acc_addr with its low LINE_OFF_W bits cleared.
- R11: With acc_valid low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_write | input | 1 | Access is a store |
| acc_is_atomic | input | 1 | Access is an atomic read-modify-write |
| acc_is_global | input | 1 | Access targets global (not thread-local) space |
| acc_addr | input | ADDR_W | Byte address of the access |
| probe_status | input | 2 | Tag probe: 0 hit, 1 miss, 2 or 3 reservation fail |
| victim_dirty | input | 1 | Way chosen for replacement holds modified data |
| victim_addr | input | ADDR_W | Line address of that way |
| mshr_hit | input | 1 | MSHR already tracks this line |
| mshr_full | input | 1 | MSHR cannot accept this line |
| mq_count | input | CNT_W | Current miss-queue occupancy |
| cfg_wpol | input | 2 | 0 read-only, 1 write-back, 2 write-through |
| cfg_shared | input | 1 | 1 shared scope, 0 private |
| cfg_walloc | input | 1 | 1 write-allocate, 0 no-write-allocate |
| result | output | 2 | 0 hit, 1 miss, 2 reservation fail |
| illegal_access | output | 1 | Write presented to a read-only cache |
| lru_touch | output | 1 | Update replacement state / reserve the way |
| line_set_modified | output | 1 | Mark the hit line dirty |
| line_invalidate | output | 1 | Invalidate the hit line |
| mshr_add | output | 1 | Record the access in the MSHR |
| ev_write_sent | output | 1 | A write entry was enqueued |
| ev_read_sent | output | 1 | A read-miss line fetch was enqueued |
| ev_wb_sent | output | 1 | A read-miss victim writeback was enqueued |
| enq_valid | output | 3 | Per-slot enqueue strobes |
| enq_kind | output | 6 | Two bits per slot: 0 write, 1 read, 2 allocate read, 3 writeback |
| enq_addr | output | 3*ADDR_W | Per-slot request address |

## Verification
The hardest case to reach is a write-allocate miss that produces all three entries. The MSHR has to be free, the victim has to be dirty, and occupancy has to sit exactly one below the n=2 limit. Moving occupancy up by one must then turn the whole access into a silent rejection. A directed task drives the tag-probe, MSHR and occupancy inputs straight to those values, then steps mq_count across the boundary. It also sets mshr_hit to open a gap between the write and the writeback, which checks that the slots are packed.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam logic [1:0] RES_HIT  = 2'd0;
  localparam logic [1:0] RES_MISS = 2'd1;
  localparam logic [1:0] RES_FAIL = 2'd2;

  localparam logic [1:0] PRB_HIT  = 2'd0;
  localparam logic [1:0] PRB_MISS = 2'd1;

  localparam logic [1:0] WP_RO = 2'd0;
  localparam logic [1:0] WP_WB = 2'd1;
  localparam logic [1:0] WP_WT = 2'd2;

  localparam logic [1:0] RQ_WRITE   = 2'd0;
  localparam logic [1:0] RQ_READ    = 2'd1;
  localparam logic [1:0] RQ_WA_READ = 2'd2;
  localparam logic [1:0] RQ_WBACK   = 2'd3;

  // Queue lacks room for an access that may add `extra` entries beyond the first check
  function automatic logic mq_short(input int unsigned occ, input int unsigned extra,
                                    input int unsigned cap);
    return (occ + extra) >= cap;
  endfunction

  // Number of queue slots that must be free (beyond occupancy) for a miss
  function automatic int unsigned miss_reserve(input logic is_write, input logic walloc,
                                               input logic read_only);
    if (is_write) return walloc ? 2 : 0;
    return read_only ? 0 : 1;
  endfunction
endpackage

// File: rtl/dcc_mshr_gate.sv
module dcc_mshr_gate (
  input  logic mshr_hit,
  input  logic mshr_full,
  input  logic mq_room,
  output logic merge,
  output logic fresh,
  output logic ok
);
  always_comb begin
    merge = mshr_hit && !mshr_full;
    fresh = !mshr_hit && !mshr_full && mq_room;
    ok    = merge || fresh;
  end

  always_comb begin
    // R7: merging and fresh allocation are exclusive
    a_r7_mshr_exclusive: assert (!(merge && fresh));
  end
endmodule

// File: rtl/dcc_hit_path.sv
module dcc_hit_path
  import dcc_pkg::*;
#(
  parameter int MQ_CAP = 8,
  localparam int CNT_W = $clog2(MQ_CAP + 1)
) (
  input  logic [1:0]       wpol,
  input  logic             shared_scope,
  input  logic             is_write,
  input  logic             is_atomic,
  input  logic             is_global,
  input  logic [CNT_W-1:0] mq_count,
  output logic             accept,
  output logic             send_write,
  output logic             touch,
  output logic             set_mod,
  output logic             invalidate
);
  logic thru;

  always_comb begin
    thru       = is_write && ((wpol == WP_WT) || (!shared_scope && is_global));
    accept     = 1'b1;
    send_write = 1'b0;
    touch      = 1'b0;
    set_mod    = 1'b0;
    invalidate = 1'b0;
    if (thru) begin
      accept     = !mq_short(int'(mq_count), 0, MQ_CAP);
      send_write = accept;
      invalidate = accept;
    end else begin
      touch   = 1'b1;
      set_mod = is_write || is_atomic;
    end
  end

  always_comb begin
    // R2: an invalidated line never also gets marked dirty or touched
    a_r2_inval_excl: assert (!(invalidate && (set_mod || touch)));
  end
endmodule

// File: rtl/dcc_miss_path.sv
module dcc_miss_path
  import dcc_pkg::*;
#(
  parameter int MQ_CAP = 8,
  localparam int CNT_W = $clog2(MQ_CAP + 1)
) (
  input  logic [1:0]       wpol,
  input  logic             walloc,
  input  logic             is_write,
  input  logic             mshr_hit,
  input  logic             mshr_full,
  input  logic             victim_dirty,
  input  logic [CNT_W-1:0] mq_count,
  output logic             accept,
  output logic             send_write,
  output logic             send_read,
  output logic             read_is_alloc,
  output logic             send_wb,
  output logic             wb_event,
  output logic             read_event,
  output logic             mshr_add,
  output logic             touch
);
  logic        read_only;
  logic        room;
  logic        g_merge, g_fresh, g_ok;
  logic        slots_ok;
  int unsigned reserve;

  assign read_only = (wpol == WP_RO);
  // A write-allocate fetch is queued behind its own write entry
  assign room = is_write ? ((int'(mq_count) + 1) < MQ_CAP) : (int'(mq_count) < MQ_CAP);

  dcc_mshr_gate u_gate (
    .mshr_hit (mshr_hit),
    .mshr_full(mshr_full),
    .mq_room  (room),
    .merge    (g_merge),
    .fresh    (g_fresh),
    .ok       (g_ok)
  );

  always_comb begin
    reserve       = miss_reserve(is_write, walloc, read_only);
    slots_ok      = !mq_short(int'(mq_count), reserve, MQ_CAP);
    accept        = 1'b0;
    send_write    = 1'b0;
    send_read     = 1'b0;
    read_is_alloc = 1'b0;
    send_wb       = 1'b0;
    wb_event      = 1'b0;
    read_event    = 1'b0;
    mshr_add      = 1'b0;
    touch         = 1'b0;
    if (is_write && !walloc) begin
      accept     = slots_ok;
      send_write = slots_ok;
    end else if (is_write) begin
      accept        = slots_ok && g_ok;
      send_write    = accept;
      send_read     = accept && g_fresh;
      read_is_alloc = 1'b1;
      send_wb       = accept && victim_dirty;
      mshr_add      = accept;
      touch         = accept;
    end else begin
      accept     = slots_ok && g_ok;
      send_read  = accept && g_fresh;
      read_event = send_read;
      send_wb    = accept && victim_dirty && !read_only;
      wb_event   = send_wb;
      mshr_add   = accept;
      touch      = accept;
    end
  end

  always_comb begin
    // R9: read-only misses never spill a victim
    a_r9_ro_no_wb: assert (!(read_only && send_wb));
    // R5: rejection leaves MSHR untouched
    a_r5_reject_clean: assert (accept || !(mshr_add || send_write || send_read || send_wb));
  end
endmodule

// File: rtl/dcc_enq_pack.sv
module dcc_enq_pack #(
  parameter int ADDR_W = 32,
  parameter int NSLOT  = 3,
  localparam int RANK_W = $clog2(NSLOT + 1)
) (
  input  logic [NSLOT-1:0]        cand_vld,
  input  logic [2*NSLOT-1:0]      cand_kind,
  input  logic [NSLOT*ADDR_W-1:0] cand_addr,
  output logic [NSLOT-1:0]        slot_vld,
  output logic [2*NSLOT-1:0]      slot_kind,
  output logic [NSLOT*ADDR_W-1:0] slot_addr
);
  logic [RANK_W-1:0] rank [NSLOT];

  // rank of a candidate = number of valid candidates ahead of it
  always_comb begin
    for (int j = 0; j < NSLOT; j++) begin
      rank[j] = '0;
      for (int k = 0; k < j; k++) rank[j] = rank[j] + RANK_W'(cand_vld[k]);
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic              v;
    logic [1:0]        kd;
    logic [ADDR_W-1:0] ad;
    always_comb begin
      v  = 1'b0;
      kd = '0;
      ad = '0;
      for (int j = 0; j < NSLOT; j++) begin
        if (cand_vld[j] && (rank[j] == RANK_W'(s))) begin
          v  = 1'b1;
          kd = cand_kind[2*j +: 2];
          ad = cand_addr[j*ADDR_W +: ADDR_W];
        end
      end
    end
    assign slot_vld[s]                 = v;
    assign slot_kind[2*s +: 2]         = kd;
    assign slot_addr[s*ADDR_W +: ADDR_W] = ad;
  end

  always_comb begin
    // R10: no entry lost or duplicated, and slots fill from the bottom
    a_r10_count_kept: assert ($countones(slot_vld) == $countones(cand_vld));
    for (int s = 1; s < NSLOT; s++)
      a_r10_no_gap: assert (!slot_vld[s] || slot_vld[s-1]);
  end
endmodule

// File: rtl/dcache_access_ctl.sv
module dcache_access_ctl
  import dcc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 7,
  parameter int MQ_CAP     = 8,
  localparam int CNT_W = $clog2(MQ_CAP + 1),
  localparam int NSLOT = 3
) (
  input  logic                    acc_valid,
  input  logic                    acc_is_write,
  input  logic                    acc_is_atomic,
  input  logic                    acc_is_global,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [1:0]              probe_status,
  input  logic                    victim_dirty,
  input  logic [ADDR_W-1:0]       victim_addr,
  input  logic                    mshr_hit,
  input  logic                    mshr_full,
  input  logic [CNT_W-1:0]        mq_count,
  input  logic [1:0]              cfg_wpol,
  input  logic                    cfg_shared,
  input  logic                    cfg_walloc,
  output logic [1:0]              result,
  output logic                    illegal_access,
  output logic                    lru_touch,
  output logic                    line_set_modified,
  output logic                    line_invalidate,
  output logic                    mshr_add,
  output logic                    ev_write_sent,
  output logic                    ev_read_sent,
  output logic                    ev_wb_sent,
  output logic [NSLOT-1:0]        enq_valid,
  output logic [2*NSLOT-1:0]      enq_kind,
  output logic [NSLOT*ADDR_W-1:0] enq_addr
);
  logic h_acc, h_wr, h_touch, h_mod, h_inv;
  logic m_acc, m_wr, m_rd, m_rd_alloc, m_wb, m_wb_ev, m_rd_ev, m_mshr, m_touch;
  logic is_hit, is_miss, illegal;
  logic [ADDR_W-1:0] line_addr;
  logic [NSLOT-1:0]        c_vld;
  logic [2*NSLOT-1:0]      c_kind;
  logic [NSLOT*ADDR_W-1:0] c_addr;

  assign line_addr = {acc_addr[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
  assign illegal   = acc_valid && acc_is_write && (cfg_wpol == WP_RO);
  assign is_hit    = acc_valid && !illegal && (probe_status == PRB_HIT);
  assign is_miss   = acc_valid && !illegal && (probe_status == PRB_MISS);

  dcc_hit_path #(.MQ_CAP(MQ_CAP)) u_hit (
    .wpol        (cfg_wpol),
    .shared_scope(cfg_shared),
    .is_write    (acc_is_write),
    .is_atomic   (acc_is_atomic),
    .is_global   (acc_is_global),
    .mq_count    (mq_count),
    .accept      (h_acc),
    .send_write  (h_wr),
    .touch       (h_touch),
    .set_mod     (h_mod),
    .invalidate  (h_inv)
  );

  dcc_miss_path #(.MQ_CAP(MQ_CAP)) u_miss (
    .wpol         (cfg_wpol),
    .walloc       (cfg_walloc),
    .is_write     (acc_is_write),
    .mshr_hit     (mshr_hit),
    .mshr_full    (mshr_full),
    .victim_dirty (victim_dirty),
    .mq_count     (mq_count),
    .accept       (m_acc),
    .send_write   (m_wr),
    .send_read    (m_rd),
    .read_is_alloc(m_rd_alloc),
    .send_wb      (m_wb),
    .wb_event     (m_wb_ev),
    .read_event   (m_rd_ev),
    .mshr_add     (m_mshr),
    .touch        (m_touch)
  );

  // Candidate order is fixed: write, read, writeback
  always_comb begin
    c_vld[0] = (is_hit && h_wr) || (is_miss && m_wr);
    c_vld[1] = is_miss && m_rd;
    c_vld[2] = is_miss && m_wb;
    c_kind   = {RQ_WBACK, (m_rd_alloc ? RQ_WA_READ : RQ_READ), RQ_WRITE};
    c_addr   = {victim_addr, line_addr, acc_addr};
  end

  dcc_enq_pack #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_pack (
    .cand_vld (c_vld),
    .cand_kind(c_kind),
    .cand_addr(c_addr),
    .slot_vld (enq_valid),
    .slot_kind(enq_kind),
    .slot_addr(enq_addr)
  );

  always_comb begin
    if (!acc_valid)   result = RES_HIT;
    else if (is_hit)  result = h_acc ? RES_HIT : RES_FAIL;
    else if (is_miss) result = m_acc ? RES_MISS : RES_FAIL;
    else              result = RES_FAIL;
    illegal_access    = illegal;
    lru_touch         = (is_hit && h_touch) || (is_miss && m_touch);
    line_set_modified = is_hit && h_mod;
    line_invalidate   = is_hit && h_inv;
    mshr_add          = is_miss && m_mshr;
    ev_write_sent     = c_vld[0];
    ev_read_sent      = is_miss && m_rd_ev;
    ev_wb_sent        = is_miss && m_wb_ev;
  end

  always_comb begin
    // R1: accepted accesses never push the queue past capacity
    a_r1_no_overflow: assert (result == RES_FAIL ||
                              (int'(mq_count) + $countones(enq_valid)) <= MQ_CAP);
    // R8 / R5: a rejection has no side effects
    a_r8_fail_quiet: assert (result != RES_FAIL ||
                             (enq_valid == '0 && !lru_touch && !line_set_modified &&
                              !line_invalidate && !mshr_add));
    // R2: invalidation goes with exactly one forwarded write in slot 0
    a_r2_inval_write: assert (!line_invalidate ||
                              (enq_valid == 3'b001 && enq_kind[1:0] == RQ_WRITE &&
                               result == RES_HIT));
    // R11: idle cycle drives nothing
    a_r11_idle: assert (acc_valid || (enq_valid == '0 && !mshr_add && !lru_touch &&
                                      !illegal_access && result == RES_HIT));
    // R9: illegal access is always rejected
    a_r9_illegal_fail: assert (!illegal_access || result == RES_FAIL);
  end
endmodule

// File: tb/dcache_access_ctl_tb.sv
module dcache_access_ctl_tb_top;
  localparam int AW  = 32;
  localparam int CAP = 8;
  localparam int CW  = $clog2(CAP + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          acc_valid, acc_is_write, acc_is_atomic, acc_is_global;
  logic [AW-1:0] acc_addr, victim_addr;
  logic [1:0]    probe_status, cfg_wpol;
  logic          victim_dirty, mshr_hit, mshr_full, cfg_shared, cfg_walloc;
  logic [CW-1:0] mq_count;
  logic [1:0]    result;
  logic          illegal_access, lru_touch, line_set_modified, line_invalidate, mshr_add;
  logic          ev_write_sent, ev_read_sent, ev_wb_sent;
  logic [2:0]    enq_valid;
  logic [5:0]    enq_kind;
  logic [3*AW-1:0] enq_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [AW-1:0] A_ACC  = 32'h0000_1234;
  localparam logic [AW-1:0] A_LINE = 32'h0000_1200;
  localparam logic [AW-1:0] A_VIC  = 32'h0000_5A80;

  dcache_access_ctl #(.ADDR_W(AW), .LINE_OFF_W(7), .MQ_CAP(CAP)) dut_i (
    .acc_valid(acc_valid), .acc_is_write(acc_is_write), .acc_is_atomic(acc_is_atomic),
    .acc_is_global(acc_is_global), .acc_addr(acc_addr), .probe_status(probe_status),
    .victim_dirty(victim_dirty), .victim_addr(victim_addr), .mshr_hit(mshr_hit),
    .mshr_full(mshr_full), .mq_count(mq_count), .cfg_wpol(cfg_wpol),
    .cfg_shared(cfg_shared), .cfg_walloc(cfg_walloc), .result(result),
    .illegal_access(illegal_access), .lru_touch(lru_touch),
    .line_set_modified(line_set_modified), .line_invalidate(line_invalidate),
    .mshr_add(mshr_add), .ev_write_sent(ev_write_sent), .ev_read_sent(ev_read_sent),
    .ev_wb_sent(ev_wb_sent), .enq_valid(enq_valid), .enq_kind(enq_kind),
    .enq_addr(enq_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    acc_valid = 1; acc_is_write = 0; acc_is_atomic = 0; acc_is_global = 1;
    acc_addr = A_ACC; victim_addr = A_VIC; probe_status = 2'd1;
    victim_dirty = 0; mshr_hit = 0; mshr_full = 0; mq_count = '0;
    cfg_wpol = 2'd1; cfg_shared = 0; cfg_walloc = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " result"}, result, 2);
    chk({tag, " enq"}, enq_valid, 0);
    chk({tag, " sidefx"}, {lru_touch, line_set_modified, line_invalidate, mshr_add}, 0);
  endtask

  task automatic t_idle();
    defaults(); acc_valid = 0; acc_is_write = 1; probe_status = 2'd0; settle();
    chk("R11 idle result", result, 0);
    chk("R11 idle outs", {illegal_access, lru_touch, line_set_modified, line_invalidate,
        mshr_add, ev_write_sent, ev_read_sent, ev_wb_sent, enq_valid}, 0);
  endtask

  task automatic t_wt_hit();
    defaults(); cfg_wpol = 2'd2; cfg_shared = 1; acc_is_write = 1; probe_status = 2'd0;
    mq_count = 7; settle();
    chk("R2 wt hit result", result, 0);
    chk("R2 wt hit enq", enq_valid, 3'b001);
    chk("R2 wt hit kind", enq_kind[1:0], 0);
    chk("R2 wt hit addr", enq_addr[AW-1:0], A_ACC);
    chk("R2 wt hit flags", {line_invalidate, ev_write_sent, lru_touch, line_set_modified}, 4'b1100);
    mq_count = 8; settle();
    chk_quiet("R1 wt hit full");
  endtask

  task automatic t_scope_hit();
    defaults(); acc_is_write = 1; probe_status = 2'd0; cfg_shared = 0; acc_is_global = 1;
    settle();
    chk("R2 private global write", {line_invalidate, enq_valid}, {1'b1, 3'b001});
    cfg_shared = 1; settle();
    chk("R3 shared write hit", {lru_touch, line_set_modified, line_invalidate, enq_valid},
        {3'b110, 3'b000});
    cfg_shared = 0; acc_is_global = 0; settle();
    chk("R3 private local write", {lru_touch, line_set_modified, enq_valid}, {2'b11, 3'b000});
    chk("R3 result", result, 0);
  endtask

  task automatic t_read_hit();
    defaults(); probe_status = 2'd0; settle();
    chk("R3 read hit", {result, lru_touch, line_set_modified, enq_valid}, {2'd0, 2'b10, 3'b000});
    acc_is_atomic = 1; settle();
    chk("R3 atomic hit", {lru_touch, line_set_modified}, 2'b11);
  endtask

  task automatic t_nwa_miss();
    defaults(); acc_is_write = 1; mq_count = 7; victim_dirty = 1; settle();
    chk("R4 nwa result", result, 1);
    chk("R4 nwa enq", {enq_valid, enq_kind[1:0], enq_addr[AW-1:0]}, {3'b001, 2'd0, A_ACC});
    chk("R4 nwa flags", {mshr_add, lru_touch, ev_write_sent}, 3'b001);
    mq_count = 8; settle();
    chk_quiet("R1 nwa full");
  endtask

  task automatic t_wa_miss();
    defaults(); acc_is_write = 1; cfg_walloc = 1; victim_dirty = 1; mq_count = 5; settle();
    chk("R6 wa result", result, 1);
    chk("R6 wa enq", enq_valid, 3'b111);
    chk("R6 wa kinds", enq_kind, {2'd3, 2'd2, 2'd0});
    chk("R6 wa addr0", enq_addr[AW-1:0], A_ACC);
    chk("R6 wa addr1", enq_addr[2*AW-1:AW], A_LINE);
    chk("R6 wa addr2", enq_addr[3*AW-1:2*AW], A_VIC);
    chk("R6 wa flags", {mshr_add, lru_touch, ev_write_sent, ev_read_sent, ev_wb_sent}, 5'b11100);
    mq_count = 6; settle();
    chk_quiet("R5 wa n2 boundary");
    chk("R5 wa no event", ev_write_sent, 0);
    mq_count = 0; mshr_full = 1; settle();
    chk_quiet("R5 wa mshr full");
    mshr_full = 0; mshr_hit = 1; settle();
    chk("R10 wa merge enq", enq_valid, 3'b011);
    chk("R10 wa merge kinds", enq_kind[3:0], {2'd3, 2'd0});
    chk("R10 wa merge addr1", enq_addr[2*AW-1:AW], A_VIC);
  endtask

  task automatic t_read_miss();
    defaults(); victim_dirty = 1; mq_count = 6; settle();
    chk("R7 rd result", result, 1);
    chk("R7 rd enq", {enq_valid, enq_kind[3:0]}, {3'b011, 2'd3, 2'd1});
    chk("R7 rd addr0", enq_addr[AW-1:0], A_LINE);
    chk("R7 rd flags", {mshr_add, lru_touch, ev_read_sent, ev_wb_sent, ev_write_sent}, 5'b11110);
    mq_count = 7; settle();
    chk_quiet("R1 rd n1 boundary");
    mq_count = 0; victim_dirty = 0; mshr_hit = 1; settle();
    chk("R7 rd merge", {result, enq_valid, mshr_add, ev_read_sent}, {2'd1, 3'b000, 2'b10});
    mshr_full = 1; settle();
    chk_quiet("R7 rd mshr full");
  endtask

  task automatic t_probe_fail();
    defaults(); probe_status = 2'd2; settle();
    chk_quiet("R8 probe fail rd");
    acc_is_write = 1; cfg_walloc = 1; probe_status = 2'd3; settle();
    chk_quiet("R8 probe fail wr");
  endtask

  task automatic t_read_only();
    defaults(); cfg_wpol = 2'd0; acc_is_write = 1; settle();
    chk("R9 ro write", {illegal_access, result}, {1'b1, 2'd2});
    chk_quiet("R9 ro write quiet");
    acc_is_write = 0; victim_dirty = 1; mq_count = 7; settle();
    chk("R9 ro read miss", {illegal_access, result, enq_valid, enq_kind[1:0], ev_wb_sent},
        {1'b0, 2'd1, 3'b001, 2'd1, 1'b0});
    mq_count = 8; settle();
    chk_quiet("R1 ro n0 boundary");
  endtask

  initial begin
    fork
      begin
        t_idle(); t_wt_hit(); t_scope_hit(); t_read_hit(); t_nwa_miss();
        t_wa_miss(); t_read_miss(); t_probe_fail(); t_read_only();
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule